// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block gathers interrupt requests from a parameterised set of maskable sources and decides, every cycle, which one (if any) the processor should take. Each source owns a latched pending flag and a 3-bit programmable level. Two global settings, a master enable and a processor priority threshold, decide which pending sources are eligible. The highest-level eligible source is presented to the processor together with its index and level.

The processor answers with an acknowledge carrying the index it took, and only that source's pending flag drops. Software uses a small write port to program levels and the global settings, and to drop pending flags. It cannot raise a pending flag. Pending flags, the global settings and the level of one selected source are always visible on output ports.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While the master enable (`en_o`) is 0, `cpu_req_o` stays 0 whatever is pending.
- R2: A 1 on `irq_req_i[k]` at a clock edge makes `pend_o[k]` read 1 after that edge, and it stays 1 until it is cleared.
- R3: An acknowledge (`ack_i`=1, `ack_idx_i`=k) clears only `pend_o[k]` at the next edge. All other pending flags keep their value.
- R4: A pending-clear write (`sw_sel_i`=0) drops every pending flag whose `sw_wdata_i` bit is 0. Data bits of 1 leave their flags unchanged, so software never sets a flag.
- R5: Level 0 disables a source: a pending source at level 0 is never presented, even with threshold 0. Levels 1 to 7 are valid and 7 ranks highest.
- R6: A source is presented only when its level is strictly greater than the threshold `ipl_o`. A threshold of 7 blocks every source.
- R7: `cpu_req_o` is 1 exactly when some source is eligible (enable 1, pending 1, level above the threshold). Then `cpu_idx_o`/`cpu_lvl_o` name the eligible source of highest level. Among equal levels, the lowest index wins.
- R8: A level write (`sw_sel_i`=1, level in `sw_wdata_i[2:0]` for source `sw_idx_i`) changes nothing but that level. A control write (`sw_sel_i`=2, enable in bit 0, threshold in bits 3:1) changes nothing but those two fields. Neither write touches a pending flag.
- R9: If a hardware request for source k arrives in the same cycle as a software clear or an acknowledge of k, `pend_o[k]` ends up 1.
- R10: After reset, all pending flags, all levels, the enable and the threshold read 0, and `cpu_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | N_SRC | Per-source hardware request, sampled each edge |
| ack_i | input | 1 | Processor accepted the presented interrupt |
| ack_idx_i | input | IDX_W | Index of the accepted source |
| sw_we_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Write target: 0 pending clear, 1 level, 2 control, 3 none |
| sw_idx_i | input | IDX_W | Source index for level write and level readback |
| sw_wdata_i | input | WD_W | Write data |
| pend_o | output | N_SRC | Pending flags |
| en_o | output | 1 | Master enable |
| ipl_o | output | 3 | Processor priority threshold |
| lvl_rd_o | output | 3 | Level of source `sw_idx_i` |
| cpu_req_o | output | 1 | An eligible interrupt is presented |
| cpu_idx_o | output | IDX_W | Index of the presented source |
| cpu_lvl_o | output | 3 | Level of the presented source |

## Verification
A hardware request can land in the same cycle as a clear of the same pending flag, either a software clear or a processor acknowledge. The bench drives a request and a clear of one source on the same falling edge. It does this once with the software clear and once with the acknowledge. After the next rising edge the flag must read 1, while a neighbouring flag cleared by the same software write must read 0.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef enum logic [1:0] {
        SEL_PCLR = 2'd0,
        SEL_LVL  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } sw_sel_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    input  logic             clr_we_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    output logic [N_SRC-1:0] pend_o
);
    typedef struct packed {
        logic [N_SRC-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) begin
            st_d.pend = st_d.pend & clr_mask_i;
        end
        if (ack_i) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (ack_idx_i == IDX_W'(i)) begin
                    st_d.pend[i] = 1'b0;
                end
            end
        end
        // new requests override any clear in the same cycle
        st_d.pend = st_d.pend | irq_req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req_i[g] |=> pend_o[g]);
        a_r4_never_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_req_i[g] && !pend_o[g]) |=> !pend_o[g]);
        a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && ack_idx_i == IDX_W'(g) && !irq_req_i[g]) |=> !pend_o[g]);
        a_r3_ack_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && ack_idx_i != IDX_W'(g) && !clr_we_i && pend_o[g]) |=> pend_o[g]);
    end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lvl_we_i,
    input  logic                        ctrl_we_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [LVL_W:0]              data_i,
    output logic                        en_o,
    output lvl_t                        ipl_o,
    output logic [N_SRC-1:0][LVL_W-1:0] lvl_o,
    output lvl_t                        lvl_rd_o
);
    typedef struct packed {
        logic                        en;
        lvl_t                        ipl;
        logic [N_SRC-1:0][LVL_W-1:0] lvl;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lvl_we_i) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (idx_i == IDX_W'(i)) begin
                    st_d.lvl[i] = data_i[LVL_W-1:0];
                end
            end
        end
        if (ctrl_we_i) begin
            st_d.en  = data_i[0];
            st_d.ipl = data_i[LVL_W:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        lvl_rd_o = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (idx_i == IDX_W'(i)) begin
                lvl_rd_o = st_q.lvl[i];
            end
        end
    end

    assign en_o  = st_q.en;
    assign ipl_o = st_q.ipl;
    assign lvl_o = st_q.lvl;

    a_r8_ctrl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we_i |=> ($stable(en_o) && $stable(ipl_o)));
    a_r8_levels_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_we_i |=> $stable(lvl_o));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0]            pend_i,
    input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
    input  logic                        en_i,
    input  lvl_t                        ipl_i,
    output logic                        req_o,
    output logic [IDX_W-1:0]            idx_o,
    output lvl_t                        lvl_o
);
    logic [N_SRC-1:0] elig;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = en_i && pend_i[g] && (lvl_i[g] > ipl_i);
    end

    always_comb begin
        req_o = 1'b0;
        idx_o = '0;
        lvl_o = '0;
        // ascending scan with strict compare keeps the lowest index on ties
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!req_o || lvl_i[i] > lvl_o)) begin
                req_o = 1'b1;
                idx_o = IDX_W'(i);
                lvl_o = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int WD_W  = (N_SRC > LVL_W + 1) ? N_SRC : LVL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    input  logic             sw_we_i,
    input  logic [1:0]       sw_sel_i,
    input  logic [IDX_W-1:0] sw_idx_i,
    input  logic [WD_W-1:0]  sw_wdata_i,
    output logic [N_SRC-1:0] pend_o,
    output logic             en_o,
    output logic [2:0]       ipl_o,
    output logic [2:0]       lvl_rd_o,
    output logic             cpu_req_o,
    output logic [IDX_W-1:0] cpu_idx_o,
    output logic [2:0]       cpu_lvl_o
);
    sw_sel_e                     sel;
    logic                        clr_we, lvl_we, ctrl_we;
    logic [N_SRC-1:0][LVL_W-1:0] lvl_all;

    assign sel     = sw_sel_e'(sw_sel_i);
    assign clr_we  = sw_we_i && (sel == SEL_PCLR);
    assign lvl_we  = sw_we_i && (sel == SEL_LVL);
    assign ctrl_we = sw_we_i && (sel == SEL_CTRL);

    irq_pend_reg #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req_i  (irq_req_i),
        .ack_i      (ack_i),
        .ack_idx_i  (ack_idx_i),
        .clr_we_i   (clr_we),
        .clr_mask_i (sw_wdata_i[N_SRC-1:0]),
        .pend_o     (pend_o)
    );

    irq_cfg_reg #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_we_i  (lvl_we),
        .ctrl_we_i (ctrl_we),
        .idx_i     (sw_idx_i),
        .data_i    (sw_wdata_i[LVL_W:0]),
        .en_o      (en_o),
        .ipl_o     (ipl_o),
        .lvl_o     (lvl_all),
        .lvl_rd_o  (lvl_rd_o)
    );

    irq_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) i_arb (
        .pend_i (pend_o),
        .lvl_i  (lvl_all),
        .en_i   (en_o),
        .ipl_i  (ipl_o),
        .req_o  (cpu_req_o),
        .idx_o  (cpu_idx_o),
        .lvl_o  (cpu_lvl_o)
    );

    a_r1_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !cpu_req_o);
    a_r6_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |-> (cpu_lvl_o > ipl_o));
    a_r5_no_level0: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |-> (cpu_lvl_o != 3'd0));

    for (genvar g = 0; g < N_SRC; g++) begin : g_win
        a_r7_no_better: assert property (@(posedge clk) disable iff (!rst_n)
            (en_o && pend_o[g] && lvl_all[g] > ipl_o) |-> (cpu_req_o && cpu_lvl_o >= lvl_all[g]));
        a_r7_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
            (en_o && pend_o[g] && lvl_all[g] > ipl_o && cpu_lvl_o == lvl_all[g])
                |-> (cpu_idx_o <= IDX_W'(g)));
    end
    a_r7_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |-> pend_o[cpu_idx_o]);
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          ack = 1'b0;
    logic [IW-1:0] ack_idx = '0;
    logic          sw_we = 1'b0;
    logic [1:0]    sw_sel = 2'd3;
    logic [IW-1:0] sw_idx = '0;
    logic [7:0]    sw_wdata = '0;
    logic [N-1:0]  pend;
    logic          en;
    logic [2:0]    ipl, lvl_rd, cpu_lvl;
    logic          cpu_req;
    logic [IW-1:0] cpu_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.N_SRC(N)) i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .ack_i(ack),
        .ack_idx_i(ack_idx), .sw_we_i(sw_we), .sw_sel_i(sw_sel),
        .sw_idx_i(sw_idx), .sw_wdata_i(sw_wdata), .pend_o(pend), .en_o(en),
        .ipl_o(ipl), .lvl_rd_o(lvl_rd), .cpu_req_o(cpu_req),
        .cpu_idx_o(cpu_idx), .cpu_lvl_o(cpu_lvl)
    );

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, int idx, int data);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_idx = IW'(idx); sw_wdata = 8'(data);
        @(negedge clk);
        sw_we = 1'b0; sw_sel = 2'd3;
    endtask

    task automatic set_lvl(int idx, int l);  wr(2'd1, idx, l); endtask
    task automatic set_ctrl(int e, int p);   wr(2'd2, 0, (p << 1) | e); endtask
    task automatic clr_pend(int keep_mask);  wr(2'd0, 0, keep_mask); endtask

    task automatic pulse(int mask);
        @(negedge clk);
        irq_req = N'(mask);
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic do_ack(int idx);
        @(negedge clk);
        ack = 1'b1; ack_idx = IW'(idx);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic read_lvl(int idx, output int l);
        sw_idx = IW'(idx);
        #1;
        l = int'(lvl_rd);
    endtask

    task automatic clean();
        clr_pend(0);
        for (int i = 0; i < N; i++) set_lvl(i, 0);
        set_ctrl(0, 0);
    endtask

    task automatic t_reset();
        int l;
        chk("R10 pend", int'(pend), 0);
        chk("R10 en", int'(en), 0);
        chk("R10 ipl", int'(ipl), 0);
        chk("R10 req", int'(cpu_req), 0);
        for (int i = 0; i < N; i++) begin
            read_lvl(i, l);
            chk("R10 lvl", l, 0);
        end
    endtask

    task automatic t_enable_gate();
        set_lvl(2, 5);
        pulse(1 << 2);
        chk("R2 pend set", int'(pend), 4);
        chk("R1 gated req", int'(cpu_req), 0);
        set_ctrl(1, 0);
        chk("R7 req", int'(cpu_req), 1);
        chk("R7 idx", int'(cpu_idx), 2);
        chk("R7 lvl", int'(cpu_lvl), 5);
        set_ctrl(0, 0);
        chk("R1 disabled again", int'(cpu_req), 0);
        chk("R8 pend kept", int'(pend), 4);
        clean();
    endtask

    task automatic t_ipl();
        set_lvl(2, 5);
        pulse(1 << 2);
        for (int p = 0; p < 8; p++) begin
            set_ctrl(1, p);
            chk("R6 threshold", int'(cpu_req), (5 > p) ? 1 : 0);
        end
        set_lvl(2, 7);
        chk("R6 ipl7 blocks", int'(cpu_req), 0);
        set_ctrl(1, 6);
        chk("R6 lvl7 over 6", int'(cpu_req), 1);
        clean();
    endtask

    task automatic t_level0();
        set_ctrl(1, 0);
        pulse(1 << 4);
        chk("R5 pend", int'(pend), 16);
        chk("R5 lvl0 no req", int'(cpu_req), 0);
        set_lvl(4, 1);
        chk("R5 lvl1 req", int'(cpu_req), 1);
        chk("R5 lvl1 idx", int'(cpu_idx), 4);
        clean();
    endtask

    task automatic t_priority();
        set_lvl(1, 3); set_lvl(3, 6); set_lvl(5, 6); set_lvl(6, 2);
        pulse(8'b0110_1010);
        set_ctrl(1, 0);
        chk("R7 top idx", int'(cpu_idx), 3);
        chk("R7 top lvl", int'(cpu_lvl), 6);
        do_ack(3);
        chk("R3 only 3 cleared", int'(pend), 8'b0110_0010);
        chk("R7 tie next", int'(cpu_idx), 5);
        do_ack(5);
        chk("R7 idx1", int'(cpu_idx), 1);
        chk("R7 lvl3", int'(cpu_lvl), 3);
        do_ack(1);
        chk("R7 idx6", int'(cpu_idx), 6);
        do_ack(6);
        chk("R3 all clear", int'(pend), 0);
        chk("R7 none", int'(cpu_req), 0);
        clean();
    endtask

    task automatic t_sw_clear();
        clr_pend(8'hFF);
        chk("R4 ones no set", int'(pend), 0);
        pulse(8'b0000_1010);
        clr_pend(8'hFD);
        chk("R4 zero clears", int'(pend), 8);
        clean();
    endtask

    task automatic t_collision();
        pulse(8'b0001_1000);
        @(negedge clk);
        irq_req = 8'b0000_1000;
        sw_we = 1'b1; sw_sel = 2'd0; sw_wdata = 8'h00;
        @(negedge clk);
        irq_req = '0; sw_we = 1'b0; sw_sel = 2'd3;
        chk("R9 req beats sw clear", int'(pend), 8);
        @(negedge clk);
        irq_req = 8'b0000_1000;
        ack = 1'b1; ack_idx = 3'd3;
        @(negedge clk);
        irq_req = '0; ack = 1'b0;
        chk("R9 req beats ack", int'(pend), 8);
        clean();
    endtask

    task automatic t_indep();
        int l;
        set_lvl(7, 4);
        pulse(1 << 0);
        set_ctrl(1, 2);
        set_lvl(0, 6);
        chk("R8 en kept", int'(en), 1);
        chk("R8 ipl kept", int'(ipl), 2);
        chk("R8 pend kept lvl", int'(pend), 1);
        set_ctrl(0, 5);
        read_lvl(7, l);
        chk("R8 lvl7 kept", l, 4);
        read_lvl(0, l);
        chk("R8 lvl0 kept", l, 6);
        chk("R8 pend kept ctrl", int'(pend), 1);
        chk("R8 ipl written", int'(ipl), 5);
        clr_pend(0);
        read_lvl(7, l);
        chk("R8 lvl after clr", l, 4);
        chk("R8 ipl after clr", int'(ipl), 5);
        clean();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_gate();
        t_ipl();
        t_level0();
        t_priority();
        t_sw_clear();
        t_collision();
        t_indep();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule